// File: doc/BRIEF.md
# NAND Multi-Plane Page Program Sequencer

This block sits on the host side of a raw NAND flash bus and writes up to four pages in one program operation, one page per plane. The host gives a plane-enable mask, the upper block bits and a page index, then pulses `start`. The page bytes arrive on a valid/ready stream. For every enabled plane, in ascending plane order, the sequencer sends a load command, the column and row address bytes, and exactly one page of data. It closes each plane except the final one with a dummy program command. The device is busy only briefly after that command, and the sequencer waits for ready before it loads the next plane. The final plane is closed with the true program command, which starts programming all loaded pages together.

Once the device is ready again, the sequencer sends the multi-plane status command and reads one status value. It reports a per-plane fail vector, limited to the planes it loaded, and an overall fail flag. A one-cycle `done` pulse marks the end. The bus is modelled as one strobe per byte: `nand_we` with `nand_cle` high carries a command, `nand_we` with `nand_ale` high carries an address byte, and `nand_we` with both low carries a data byte. `nand_re` is the status read strobe.

The state machine has these states: IDLE, LOAD_CMD, ADDR, DATA, END_CMD, WAIT_WB, WAIT_RDY, STAT_CMD, STAT_READ and DONE. Its transitions are as follows:
- IDLE goes to LOAD_CMD on start, or to DONE on start with an empty mask.
- LOAD_CMD goes to ADDR.
- ADDR goes to DATA after the last address byte.
- DATA goes to END_CMD after the last accepted byte.
- END_CMD goes to WAIT_WB.
- WAIT_WB goes to WAIT_RDY after the wait window.
- WAIT_RDY goes back to LOAD_CMD when ready and more planes remain, or to STAT_CMD when ready after the final plane.
- STAT_CMD goes to STAT_READ.
- STAT_READ goes to DONE.
- DONE goes to IDLE.

Top module: `nand_mp_prog`

## Requirements
- R1: For each loaded plane p the bus shows command 0x80 (cle=1), then COL_CYC address bytes of value 0 (ale=1), then ROW_CYC address bytes of the row {blk_hi, p[1:0], page}, least significant byte first. Planes are loaded in ascending index.
- R2: Each plane's load carries exactly PAGE_LEN data bytes (cle=0, ale=0), taken from the input stream in arrival order. A data strobe occurs only in a cycle where din_valid and din_ready are both high.
- R3: Every loaded plane except the highest-indexed one ends with command 0x11. The highest one ends with command 0x10, issued exactly once. With one plane enabled, no 0x11 appears.
- R4: Planes whose mask bit is 0 receive no 0x80 command, no address and no data.
- R5: No write or read strobe is issued while nand_rdy is low. After a 0x11 or 0x10 command, no strobe is issued before WB_CYC cycles have passed and nand_rdy is high.
- R6: After programming, command 0x71 is issued, followed by exactly one read strobe. fail_vec[p] equals status bit p+1 ANDed with the latched mask bit p, and any_fail equals status bit 0.
- R7: Command 0x01 is never issued.
- R8: done is high for exactly one cycle per operation, and busy is high from the cycle after start until the cycle after done. A start pulse while busy has no effect.
- R9: A start with an all-zero mask produces done in the next cycle, no bus strobes, and fail_vec = 0 with any_fail = 0.
- R10: After reset, busy, done, all bus strobes, din_ready, fail_vec and any_fail are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts an operation when idle |
| plane_mask | input | NPL | Planes to program, bit p = plane p |
| blk_hi | input | BLKHI_W | Block address bits above the plane bits |
| page | input | PAGE_W | Page index within the block |
| din_data | input | 8 | Page data byte stream |
| din_valid | input | 1 | Stream byte valid |
| din_ready | output | 1 | Sequencer accepts a stream byte |
| nand_io | output | 8 | Byte driven to the flash bus |
| nand_cle | output | 1 | Current strobe carries a command |
| nand_ale | output | 1 | Current strobe carries an address byte |
| nand_we | output | 1 | One-cycle write strobe per byte |
| nand_re | output | 1 | One-cycle status read strobe |
| nand_status | input | NPL+1 | Status bits 0..NPL returned during a read strobe |
| nand_rdy | input | 1 | Device ready (1) or busy (0) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| fail_vec | output | NPL | Per-plane program failure |
| any_fail | output | 1 | Overall failure flag from status bit 0 |

## Verification
The sequencer is exercised with all four planes enabled at full stream rate, with two separated planes under a throttled stream, with a single high plane, and with an adjacent pair during which a second start is attempted. An empty mask is also run. The full-rate case fixes the ordering and the chaining with dummy commands. The throttled case separates correct handshaking from strobes that run ahead of valid data. The single-plane case shows that the dummy step is dropped and that status bits of unloaded planes are masked. The restart case shows that a mid-run start is ignored. The device model holds ready low after each closing command, so strobes that do not wait for ready are caught, and it injects fail bits to exercise the status decoding.

// File: rtl/nand_mp_pkg.sv
package nand_mp_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOAD_CMD,
        ST_ADDR,
        ST_DATA,
        ST_END_CMD,
        ST_WAIT_WB,
        ST_WAIT_RDY,
        ST_STAT_CMD,
        ST_STAT_READ,
        ST_DONE
    } mp_state_t;

    localparam logic [7:0] OP_LOAD  = 8'h80;
    localparam logic [7:0] OP_DUMMY = 8'h11;
    localparam logic [7:0] OP_PROG  = 8'h10;
    localparam logic [7:0] OP_MSTAT = 8'h71;

endpackage

// File: rtl/mp_count.sv
// Wrapping event counter; last is high on the final count of a window.
module mp_count #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q;

    assign last = (cnt_q == W'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mp_plane_pick.sv
// Finds the lowest plane still to be loaded and whether it is the final one.
module mp_plane_pick #(
    parameter int NPL   = 4,
    parameter int IDX_W = $clog2(NPL)
) (
    input  logic [NPL-1:0]   rem,
    output logic [IDX_W-1:0] idx,
    output logic             is_last
);
    always_comb begin
        idx = '0;
        for (int i = NPL - 1; i >= 0; i--) begin
            if (rem[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign is_last = ($countones(rem) == 1);
endmodule

// File: rtl/mp_addr_bytes.sv
// Builds the address cycle bytes: zero column bytes, then row bytes low first.
module mp_addr_bytes #(
    parameter int COL_CYC = 2,
    parameter int ROW_W   = 18,
    parameter int SEL_W   = 3
) (
    input  logic [ROW_W-1:0] row,
    input  logic [SEL_W-1:0] sel,
    output logic [7:0]       byte_o
);
    localparam int ROW_CYC = (ROW_W + 7) / 8;
    localparam int NB      = COL_CYC + ROW_CYC;

    logic [ROW_CYC*8-1:0] row_pad;
    logic [7:0]           bytes [NB];

    assign row_pad = (ROW_CYC * 8)'(row);

    for (genvar c = 0; c < COL_CYC; c++) begin : g_col
        assign bytes[c] = 8'h00;
    end

    for (genvar r = 0; r < ROW_CYC; r++) begin : g_row
        assign bytes[COL_CYC + r] = row_pad[r*8 +: 8];
    end

    assign byte_o = bytes[sel];
endmodule

// File: rtl/nand_mp_prog.sv
module nand_mp_prog
    import nand_mp_pkg::*;
#(
    parameter int NPL      = 4,
    parameter int PAGE_LEN = 528,
    parameter int COL_CYC  = 2,
    parameter int PAGE_W   = 5,
    parameter int BLKHI_W  = 11,
    parameter int WB_CYC   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [NPL-1:0]     plane_mask,
    input  logic [BLKHI_W-1:0] blk_hi,
    input  logic [PAGE_W-1:0]  page,
    input  logic [7:0]         din_data,
    input  logic               din_valid,
    output logic               din_ready,
    output logic [7:0]         nand_io,
    output logic               nand_cle,
    output logic               nand_ale,
    output logic               nand_we,
    output logic               nand_re,
    input  logic [NPL:0]       nand_status,
    input  logic               nand_rdy,
    output logic               busy,
    output logic               done,
    output logic [NPL-1:0]     fail_vec,
    output logic               any_fail
);
    localparam int IDX_W   = $clog2(NPL);
    localparam int ROW_W   = BLKHI_W + IDX_W + PAGE_W;
    localparam int ROW_CYC = (ROW_W + 7) / 8;
    localparam int NB      = COL_CYC + ROW_CYC;
    localparam int AIW     = $clog2(NB + 1);

    mp_state_t state_q, state_d;

    logic [NPL-1:0]     mask_q;
    logic [NPL-1:0]     rem_q;
    logic [BLKHI_W-1:0] blk_q;
    logic [PAGE_W-1:0]  page_q;
    logic               last_q;
    logic [AIW-1:0]     addr_idx_q;

    logic [IDX_W-1:0]   pick_idx;
    logic               pick_last;
    logic [7:0]         addr_byte;
    logic               addr_last;
    logic               data_last;
    logic               wb_last;
    logic               accept;

    // ---------------------------------------------------------------
    // Helpers
    // ---------------------------------------------------------------
    mp_plane_pick #(
        .NPL   (NPL),
        .IDX_W (IDX_W)
    ) i_pick (
        .rem     (rem_q),
        .idx     (pick_idx),
        .is_last (pick_last)
    );

    mp_addr_bytes #(
        .COL_CYC (COL_CYC),
        .ROW_W   (ROW_W),
        .SEL_W   (AIW)
    ) i_addr (
        .row    ({blk_q, pick_idx, page_q}),
        .sel    (addr_idx_q),
        .byte_o (addr_byte)
    );

    mp_count #(
        .LIMIT (PAGE_LEN)
    ) i_data_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_DATA),
        .inc   (accept),
        .last  (data_last)
    );

    mp_count #(
        .LIMIT (WB_CYC)
    ) i_wb_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_WAIT_WB),
        .inc   (state_q == ST_WAIT_WB),
        .last  (wb_last)
    );

    assign accept    = (state_q == ST_DATA) && din_valid;
    assign addr_last = (addr_idx_q == AIW'(NB - 1));

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------------------------------------------------------
    // Next state
    // ---------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (plane_mask == '0) ? ST_DONE : ST_LOAD_CMD;
                end
            end
            ST_LOAD_CMD:  state_d = ST_ADDR;
            ST_ADDR: begin
                if (addr_last) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (accept && data_last) state_d = ST_END_CMD;
            end
            ST_END_CMD:   state_d = ST_WAIT_WB;
            ST_WAIT_WB: begin
                if (wb_last) state_d = ST_WAIT_RDY;
            end
            ST_WAIT_RDY: begin
                if (nand_rdy) state_d = last_q ? ST_STAT_CMD : ST_LOAD_CMD;
            end
            ST_STAT_CMD:  state_d = ST_STAT_READ;
            ST_STAT_READ: state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
        endcase
    end

    // ---------------------------------------------------------------
    // Outputs
    // ---------------------------------------------------------------
    always_comb begin
        nand_io   = 8'h00;
        nand_cle  = 1'b0;
        nand_ale  = 1'b0;
        nand_we   = 1'b0;
        nand_re   = 1'b0;
        din_ready = 1'b0;
        unique case (state_q)
            ST_LOAD_CMD: begin
                nand_io  = OP_LOAD;
                nand_cle = 1'b1;
                nand_we  = 1'b1;
            end
            ST_ADDR: begin
                nand_io  = addr_byte;
                nand_ale = 1'b1;
                nand_we  = 1'b1;
            end
            ST_DATA: begin
                nand_io   = din_data;
                nand_we   = din_valid;
                din_ready = 1'b1;
            end
            ST_END_CMD: begin
                nand_io  = pick_last ? OP_PROG : OP_DUMMY;
                nand_cle = 1'b1;
                nand_we  = 1'b1;
            end
            ST_STAT_CMD: begin
                nand_io  = OP_MSTAT;
                nand_cle = 1'b1;
                nand_we  = 1'b1;
            end
            ST_STAT_READ: begin
                nand_re = 1'b1;
            end
            ST_IDLE, ST_WAIT_WB, ST_WAIT_RDY, ST_DONE: begin
            end
        endcase
    end

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_DONE);

    // ---------------------------------------------------------------
    // Operation context and result registers
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '0;
            rem_q    <= '0;
            blk_q    <= '0;
            page_q   <= '0;
            last_q   <= 1'b0;
            fail_vec <= '0;
            any_fail <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                mask_q   <= plane_mask;
                rem_q    <= plane_mask;
                blk_q    <= blk_hi;
                page_q   <= page;
                last_q   <= 1'b0;
                fail_vec <= '0;
                any_fail <= 1'b0;
            end
            if (state_q == ST_END_CMD) begin
                rem_q[pick_idx] <= 1'b0;
                last_q          <= pick_last;
            end
            if (state_q == ST_STAT_READ) begin
                fail_vec <= nand_status[NPL:1] & mask_q;
                any_fail <= nand_status[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_idx_q <= '0;
        end else if (state_q == ST_ADDR) begin
            addr_idx_q <= addr_last ? '0 : addr_idx_q + 1'b1;
        end else begin
            addr_idx_q <= '0;
        end
    end
endmodule

// File: rtl/nand_mp_prog_chk.sv
module nand_mp_prog_chk #(
    parameter int NPL = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [7:0]     nand_io,
    input logic           nand_cle,
    input logic           nand_ale,
    input logic           nand_we,
    input logic           nand_re,
    input logic           nand_rdy,
    input logic           din_valid,
    input logic           din_ready,
    input logic           done,
    input logic [NPL-1:0] fail_vec,
    input logic [NPL-1:0] mask_q
);
    // R7
    no_ptr_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_we && nand_cle) |-> (nand_io != 8'h01));

    // R5
    strobe_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_we || nand_re) |-> nand_rdy);

    // R2
    data_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_we && !nand_cle && !nand_ale) |-> (din_valid && din_ready));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    fail_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((fail_vec & ~mask_q) == '0));
endmodule

bind nand_mp_prog nand_mp_prog_chk #(.NPL(NPL)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .nand_io   (nand_io),
    .nand_cle  (nand_cle),
    .nand_ale  (nand_ale),
    .nand_we   (nand_we),
    .nand_re   (nand_re),
    .nand_rdy  (nand_rdy),
    .din_valid (din_valid),
    .din_ready (din_ready),
    .done      (done),
    .fail_vec  (fail_vec),
    .mask_q    (mask_q)
);

// File: tb/test_nand_mp_prog.sv
`timescale 1ns/1ps
module test_nand_mp_prog;
    localparam int NPL      = 4;
    localparam int PAGE_LEN = 6;
    localparam int COL_CYC  = 2;
    localparam int PAGE_W   = 6;
    localparam int BLKHI_W  = 11;
    localparam int WB_CYC   = 2;
    localparam int ROW_CYC  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NPL-1:0] plane_mask = '0;
    logic [BLKHI_W-1:0] blk_hi = '0;
    logic [PAGE_W-1:0] page = '0;
    logic [7:0] din_data = 8'h00;
    logic din_valid = 1'b0;
    logic din_ready;
    logic [7:0] nand_io;
    logic nand_cle, nand_ale, nand_we, nand_re;
    logic [NPL:0] nand_status;
    logic nand_rdy;
    logic busy, done, any_fail;
    logic [NPL-1:0] fail_vec;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    nand_mp_prog #(
        .NPL(NPL), .PAGE_LEN(PAGE_LEN), .COL_CYC(COL_CYC),
        .PAGE_W(PAGE_W), .BLKHI_W(BLKHI_W), .WB_CYC(WB_CYC)
    ) i_nand_mp_prog (
        .clk(clk), .rst_n(rst_n), .start(start), .plane_mask(plane_mask),
        .blk_hi(blk_hi), .page(page), .din_data(din_data),
        .din_valid(din_valid), .din_ready(din_ready), .nand_io(nand_io),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we(nand_we),
        .nand_re(nand_re), .nand_status(nand_status), .nand_rdy(nand_rdy),
        .busy(busy), .done(done), .fail_vec(fail_vec), .any_fail(any_fail)
    );

    // ---------------- device model ----------------
    int busy_cnt;
    logic [NPL-1:0] inj = '0;
    logic [NPL-1:0] cur_mask = '0;
    assign nand_rdy    = (busy_cnt == 0);
    assign nand_status = {inj, |(inj & cur_mask)};

    always @(posedge clk) begin
        if (!rst_n) busy_cnt <= 0;
        else if (nand_we && nand_cle && nand_io == 8'h11) busy_cnt <= 3;
        else if (nand_we && nand_cle && nand_io == 8'h10) busy_cnt <= 25;
        else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    end

    // bus log: kind 0 cmd, 1 addr, 2 data, 3 read
    logic [1:0] lk [0:511];
    logic [7:0] lv [0:511];
    int ev_n;
    int viol;
    always @(posedge clk) begin
        if (!rst_n) begin
            ev_n <= 0;
            viol <= 0;
        end else begin
            if (nand_we || nand_re) begin
                lk[ev_n] <= nand_re ? 2'd3 : (nand_cle ? 2'd0 : (nand_ale ? 2'd1 : 2'd2));
                lv[ev_n] <= nand_re ? 8'h00 : nand_io;
                ev_n <= ev_n + 1;
            end
            if ((nand_we || nand_re) && !nand_rdy) viol <= viol + 1;
        end
    end

    // ---------------- data source ----------------
    int seq = 0;
    int tcnt = 0;
    bit throttle = 1'b0;
    always @(negedge clk) begin
        tcnt      <= tcnt + 1;
        din_valid <= throttle ? ((tcnt % 3) != 0) : 1'b1;
        din_data  <= 8'(seq) ^ 8'hA5;
    end
    always @(posedge clk) begin
        if (din_valid && din_ready) seq <= seq + 1;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] mask, input logic [10:0] bh,
                       input logic [5:0] pg, input logic [3:0] inj_i,
                       input bit thr, input bit restart, input string name);
        logic [1:0] ek [0:127];
        logic [7:0] ev [0:127];
        int en = 0;
        int base, s0, v0, cyc, lastp, k, bad, firstbad;
        int n80 = 0, n11 = 0, n10 = 0, n01 = 0, nd = 0;
        logic [23:0] row;
        @(negedge clk);
        throttle = thr;
        inj = inj_i;
        cur_mask = mask;
        base = ev_n;
        s0 = seq;
        v0 = viol;
        plane_mask = mask;
        blk_hi = bh;
        page = pg;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R8 busy from the cycle after start
        chk(busy == 1'b1, {name, " R8 busy after start"}, busy, 1);
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (restart && cyc == 12) begin
                plane_mask = 4'hF;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                plane_mask = mask;
                cyc++;
            end
        end
        chk(done == 1'b1, {name, " R8 done seen"}, done, 1);
        // R6 status decode
        chk(fail_vec == (inj_i & mask), {name, " R6 fail_vec"}, fail_vec, inj_i & mask);
        chk(any_fail == |(inj_i & mask), {name, " R6 any_fail"}, any_fail, |(inj_i & mask));
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, {name, " R8 done one cycle then idle"},
            {done, busy}, 0);

        // expected bus sequence
        lastp = -1;
        for (int p = 0; p < 4; p++) if (mask[p]) lastp = p;
        k = 0;
        for (int p = 0; p < 4; p++) begin
            if (mask[p]) begin
                ek[en] = 2'd0; ev[en] = 8'h80; en++;
                for (int c = 0; c < COL_CYC; c++) begin ek[en] = 2'd1; ev[en] = 8'h00; en++; end
                row = 24'({bh, 2'(p), pg});
                for (int b = 0; b < ROW_CYC; b++) begin ek[en] = 2'd1; ev[en] = row[b*8 +: 8]; en++; end
                for (int i = 0; i < PAGE_LEN; i++) begin
                    ek[en] = 2'd2; ev[en] = 8'(s0 + k) ^ 8'hA5; en++; k++;
                end
                ek[en] = 2'd0; ev[en] = (p == lastp) ? 8'h10 : 8'h11; en++;
            end
        end
        if (mask != 0) begin
            ek[en] = 2'd0; ev[en] = 8'h71; en++;
            ek[en] = 2'd3; ev[en] = 8'h00; en++;
        end

        chk(ev_n - base == en, {name, " R1,R2,R6 event count"}, ev_n - base, en);
        bad = 0;
        firstbad = -1;
        for (int i = 0; i < en && i < ev_n - base; i++) begin
            if (lk[base+i] != ek[i] || lv[base+i] != ev[i]) begin
                bad++;
                if (firstbad < 0) firstbad = i;
            end
        end
        if (firstbad >= 0)
            chk(1'b0, {name, " R1,R2,R3 bus sequence"},
                {lk[base+firstbad], lv[base+firstbad]}, {ek[firstbad], ev[firstbad]});
        else
            chk(1'b1, {name, " R1,R2,R3 bus sequence"}, 0, 0);

        for (int i = base; i < ev_n; i++) begin
            if (lk[i] == 2'd0 && lv[i] == 8'h80) n80++;
            if (lk[i] == 2'd0 && lv[i] == 8'h11) n11++;
            if (lk[i] == 2'd0 && lv[i] == 8'h10) n10++;
            if (lk[i] == 2'd0 && lv[i] == 8'h01) n01++;
            if (lk[i] == 2'd2) nd++;
        end
        chk(n80 == $countones(mask), {name, " R4 load commands"}, n80, $countones(mask));
        chk(n11 == ((mask != 0) ? $countones(mask) - 1 : 0), {name, " R3 dummy commands"},
            n11, (mask != 0) ? $countones(mask) - 1 : 0);
        chk(n10 == ((mask != 0) ? 1 : 0), {name, " R3 true program commands"}, n10, mask != 0);
        chk(n01 == 0, {name, " R7 no 0x01"}, n01, 0);
        chk(nd == $countones(mask) * PAGE_LEN, {name, " R2 data bytes"}, nd,
            $countones(mask) * PAGE_LEN);
        chk(viol == v0, {name, " R5 strobes while busy"}, viol - v0, 0);
        chk(seq - s0 == $countones(mask) * PAGE_LEN, {name, " R2 stream bytes taken"},
            seq - s0, $countones(mask) * PAGE_LEN);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk({busy, done, nand_we, nand_re, nand_cle, nand_ale, din_ready} == 7'b0,
            "R10 idle outputs", {busy, done, nand_we, nand_re, nand_cle, nand_ale, din_ready}, 0);
        chk(fail_vec == 0 && any_fail == 0, "R10 results cleared", {fail_vec, any_fail}, 0);
    endtask

    task automatic t_all_planes();
        run(4'b1111, 11'h5A3, 6'h2C, 4'b0000, 1'b0, 1'b0, "all");
    endtask

    task automatic t_split_throttled();
        run(4'b0101, 11'h123, 6'h05, 4'b0100, 1'b1, 1'b0, "split");
    endtask

    task automatic t_single_plane();
        // R3 single plane: no dummy; R6 status bits of unloaded planes masked
        run(4'b1000, 11'h7FF, 6'h3F, 4'b0110, 1'b0, 1'b0, "single");
    endtask

    task automatic t_restart_ignored();
        // R8 start while busy has no effect
        run(4'b0110, 11'h0F0, 6'h11, 4'b0010, 1'b1, 1'b1, "restart");
    endtask

    task automatic t_empty_mask();
        int base;
        @(negedge clk);
        base = ev_n;
        plane_mask = 4'b0000;
        inj = 4'b1111;
        cur_mask = 4'b0000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R9 done next cycle", done, 1);
        chk(fail_vec == 0 && any_fail == 0, "R9 no failure", {fail_vec, any_fail}, 0);
        @(negedge clk);
        chk(ev_n == base && done == 1'b0, "R9 no bus strobes", ev_n - base, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_all_planes();
        t_split_throttled();
        t_single_plane();
        t_restart_ignored();
        t_empty_mask();
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule